// File: doc/BRIEF.md
# Privilege Level and Trap Routing Unit

This block holds the current privilege level (user, supervisor or machine) of a small 32-bit RISC-V core. It handles the privilege side of trap entry and of trap return. A trap request carries a cause code, or a flag that marks an environment call, together with the program counter of the faulting instruction. The block decides whether the trap is handled in machine or supervisor mode. It saves the previous state into the matching status, exception-PC and cause registers, and returns the handler address as a redirect target in the same cycle. The mret and sret strobes undo that state and redirect to the saved exception PC.

Software updates to the status word, the two trap vector registers and the exception delegation mask arrive as write strobes that are already decoded. The status word exposes four fields at their architectural positions: MIE at bit 3, MPIE at bit 7, SPP at bit 8 and MPP at bits 12:11. All other bits read as zero. Pipeline flushing, instruction decode, interrupt logic and the rest of the CSR file are handled outside this block.

Top module: `privTrapUnit`

## Requirements
- R1: After reset the privilege is machine (2'b11), mstatus reads 0x1800 (MPP=11, all else 0), mepc, mcause, sepc and scause read 0, and the vectors and delegation mask are 0. The privilege never takes the reserved value 2'b10.
- R2: When trapIsEcall is set, the cause is taken from the privilege in force at the call: 8 from user (00), 9 from supervisor (01), 11 from machine (11). The trapCause input is ignored in that case.
- R3: A trap that is not delegated writes the old privilege into MPP, sets the privilege to machine, stores trapEpc in mepc and the cause (zero-extended) in mcause, and redirects to the mtvec base.
- R4: A machine-mode trap copies MIE into MPIE and clears MIE. mret copies MPIE into MIE and sets MPIE to 1.
- R5: mret loads the privilege from MPP, sets MPP to machine (11) and redirects to mepc.
- R6: A status write stores MIE (bit 3), MPIE (bit 7) and SPP (bit 8) as written. It stores MPP (bits 12:11) as 11 when 11 is written and as 01 for any of 00, 01 or 10.
- R7: mtvec and stvec keep the full base in bits 31:2, and the low two mode bits are ignored. A handler written as 0x51F9 is reached at exactly 0x51F8.
- R8: A trap taken while the privilege is not machine, and whose cause selects a set medeleg bit, goes to stvec. It stores trapEpc in sepc and the cause in scause, sets SPP to 1 if the trap came from supervisor and to 0 if it came from user, and enters supervisor mode. MPP, MIE, MPIE, mepc and mcause are left unchanged.
- R9: sret sets the privilege to {1'b0, SPP}, clears SPP and redirects to sepc.
- R10: Order of priority within a cycle: trap, then mret, then sret, then a status write. Only the winner acts. Writes to the vectors and to medeleg always take effect after the current cycle's routing.
- R11: In machine mode the delegation mask is ignored, and every trap goes to mtvec.
- R12: redirectValid is high in exactly the cycles that carry a trap, mret or sret.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapReq | input | 1 | Take a trap this cycle |
| trapIsEcall | input | 1 | The trap is an environment call (cause derived from privilege) |
| trapCause | input | CAUSE_W | Exception cause when not an environment call |
| trapEpc | input | XLEN | PC of the trapping instruction |
| mretReq | input | 1 | Machine return strobe |
| sretReq | input | 1 | Supervisor return strobe |
| mstatusWe | input | 1 | Status word write strobe |
| mstatusWdata | input | XLEN | Status word write data |
| mtvecWe | input | 1 | Machine vector write strobe |
| mtvecWdata | input | XLEN | Machine vector write data |
| stvecWe | input | 1 | Supervisor vector write strobe |
| stvecWdata | input | XLEN | Supervisor vector write data |
| medelegWe | input | 1 | Delegation mask write strobe |
| medelegWdata | input | 2**CAUSE_W | Delegation mask write data, one bit per cause |
| curPriv | output | 2 | Current privilege level |
| redirectValid | output | 1 | Redirect target is valid this cycle |
| redirectPc | output | XLEN | Handler or return address |
| mstatus | output | XLEN | Status word |
| mepc | output | XLEN | Machine exception PC |
| mcause | output | XLEN | Machine trap cause |
| sepc | output | XLEN | Supervisor exception PC |
| scause | output | XLEN | Supervisor trap cause |

## Verification
Several properties are checked on every cycle by assertions. The privilege never takes the reserved encoding. A machine trap lands in machine mode with MPP holding the old level. A delegated trap lands in supervisor mode with the correct SPP. Each return restores the privilege from the saved field and resets that field. No trap is delegated while in machine mode. A winning status write always leaves MPP in a supported encoding. Some behaviour only the bench scenarios can show: the exact cause values chosen for environment calls, correct indexing of the delegation mask by cause, full-width vector addresses, the MIE/MPIE round trip, and which operation wins when several strobes collide. The bench covers these with sweeps over every cause, every starting privilege and both settings of the delegation bit.

// File: rtl/privPkg.sv
package privPkg;
  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam int ECALL_U_CODE = 8;
  localparam int ECALL_S_CODE = 9;
  localparam int ECALL_M_CODE = 11;

  // status word field positions (architectural)
  localparam int ST_MIE  = 3;
  localparam int ST_MPIE = 7;
  localparam int ST_SPP  = 8;
  localparam int ST_MPP  = 11;

  typedef struct packed {
    logic enterM;
    logic enterS;
    logic leaveM;
    logic leaveS;
    logic writeStatus;
  } trapCmd_t;
endpackage

// File: rtl/privCtrl.sv
module privCtrl
  import privPkg::*;
#(
  parameter int CAUSE_W = 5,
  localparam int NUM_CAUSE = 1 << CAUSE_W
) (
  input  logic                 trapReq,
  input  logic                 trapIsEcall,
  input  logic [CAUSE_W-1:0]   trapCause,
  input  logic                 mretReq,
  input  logic                 sretReq,
  input  logic                 mstatusWe,
  input  logic [1:0]           curPriv,
  input  logic [NUM_CAUSE-1:0] medeleg,
  output trapCmd_t             cmd,
  output logic [CAUSE_W-1:0]   effCause
);
  logic delegate;

  always_comb begin
    if (trapIsEcall) begin
      unique case (curPriv)
        PRIV_U:  effCause = CAUSE_W'(ECALL_U_CODE);
        PRIV_S:  effCause = CAUSE_W'(ECALL_S_CODE);
        default: effCause = CAUSE_W'(ECALL_M_CODE);
      endcase
    end else begin
      effCause = trapCause;
    end
  end

  assign delegate = (curPriv != PRIV_M) && medeleg[effCause];

  always_comb begin
    cmd.enterM      = trapReq && !delegate;
    cmd.enterS      = trapReq && delegate;
    cmd.leaveM      = mretReq && !trapReq;
    cmd.leaveS      = sretReq && !trapReq && !mretReq;
    cmd.writeStatus = mstatusWe && !(trapReq || mretReq || sretReq);
  end
endmodule

// File: rtl/privDatapath.sv
module privDatapath
  import privPkg::*;
#(
  parameter int XLEN = 32,
  parameter int CAUSE_W = 5,
  localparam int NUM_CAUSE = 1 << CAUSE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  trapCmd_t             cmd,
  input  logic [CAUSE_W-1:0]   effCause,
  input  logic [XLEN-1:0]      trapEpc,
  input  logic [XLEN-1:0]      mstatusWdata,
  input  logic                 mtvecWe,
  input  logic [XLEN-1:0]      mtvecWdata,
  input  logic                 stvecWe,
  input  logic [XLEN-1:0]      stvecWdata,
  input  logic                 medelegWe,
  input  logic [NUM_CAUSE-1:0] medelegWdata,
  output logic [1:0]           curPriv,
  output logic [NUM_CAUSE-1:0] medeleg,
  output logic [XLEN-1:0]      redirectPc,
  output logic [XLEN-1:0]      mstatus,
  output logic [XLEN-1:0]      mepc,
  output logic [XLEN-1:0]      mcause,
  output logic [XLEN-1:0]      sepc,
  output logic [XLEN-1:0]      scause
);
  logic [1:0]      mppQ;
  logic            sppQ, mieQ, mpieQ;
  logic [XLEN-3:0] mtvecBase, stvecBase;
  logic [XLEN-1:0] causeExt;

  assign causeExt = {{(XLEN-CAUSE_W){1'b0}}, effCause};

  function automatic logic [1:0] clampMpp(input logic [1:0] v);
    return (v == PRIV_M) ? PRIV_M : PRIV_S;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPriv <= PRIV_M;
      mppQ    <= PRIV_M;
      sppQ    <= 1'b0;
      mieQ    <= 1'b0;
      mpieQ   <= 1'b0;
      mepc    <= '0;
      mcause  <= '0;
      sepc    <= '0;
      scause  <= '0;
    end else if (cmd.enterM) begin
      mppQ    <= curPriv;
      curPriv <= PRIV_M;
      mpieQ   <= mieQ;
      mieQ    <= 1'b0;
      mepc    <= trapEpc;
      mcause  <= causeExt;
    end else if (cmd.enterS) begin
      sppQ    <= (curPriv == PRIV_S);
      curPriv <= PRIV_S;
      sepc    <= trapEpc;
      scause  <= causeExt;
    end else if (cmd.leaveM) begin
      curPriv <= mppQ;
      mppQ    <= PRIV_M;
      mieQ    <= mpieQ;
      mpieQ   <= 1'b1;
    end else if (cmd.leaveS) begin
      curPriv <= {1'b0, sppQ};
      sppQ    <= 1'b0;
    end else if (cmd.writeStatus) begin
      mieQ  <= mstatusWdata[ST_MIE];
      mpieQ <= mstatusWdata[ST_MPIE];
      sppQ  <= mstatusWdata[ST_SPP];
      mppQ  <= clampMpp(mstatusWdata[ST_MPP +: 2]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mtvecBase <= '0;
      stvecBase <= '0;
      medeleg   <= '0;
    end else begin
      if (mtvecWe)   mtvecBase <= mtvecWdata[XLEN-1:2];
      if (stvecWe)   stvecBase <= stvecWdata[XLEN-1:2];
      if (medelegWe) medeleg   <= medelegWdata;
    end
  end

  always_comb begin
    mstatus = '0;
    mstatus[ST_MIE]      = mieQ;
    mstatus[ST_MPIE]     = mpieQ;
    mstatus[ST_SPP]      = sppQ;
    mstatus[ST_MPP +: 2] = mppQ;
  end

  always_comb begin
    if (cmd.enterM)      redirectPc = {mtvecBase, 2'b00};
    else if (cmd.enterS) redirectPc = {stvecBase, 2'b00};
    else if (cmd.leaveM) redirectPc = mepc;
    else                 redirectPc = sepc;
  end

  // R1
  legal_priv_chk: assert property (@(posedge clk) disable iff (!rstN)
    curPriv != 2'b10);
  // R3
  trap_to_m_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.enterM |=> (curPriv == PRIV_M) && (mppQ == $past(curPriv)));
  // R8
  trap_to_s_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.enterS |=> (curPriv == PRIV_S) && (sppQ == ($past(curPriv) == PRIV_S)));
  // R5
  mret_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.leaveM |=> (curPriv == $past(mppQ)) && (mppQ == PRIV_M));
  // R9
  sret_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.leaveS |=> (curPriv == {1'b0, $past(sppQ)}) && !sppQ);
  // R6
  mpp_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.writeStatus |=> mppQ[0]);
  // R11
  no_deleg_from_m_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.enterS && curPriv == PRIV_M));
endmodule

// File: rtl/privTrapUnit.sv
module privTrapUnit
  import privPkg::*;
#(
  parameter int XLEN = 32,
  parameter int CAUSE_W = 5,
  localparam int NUM_CAUSE = 1 << CAUSE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 trapReq,
  input  logic                 trapIsEcall,
  input  logic [CAUSE_W-1:0]   trapCause,
  input  logic [XLEN-1:0]      trapEpc,
  input  logic                 mretReq,
  input  logic                 sretReq,
  input  logic                 mstatusWe,
  input  logic [XLEN-1:0]      mstatusWdata,
  input  logic                 mtvecWe,
  input  logic [XLEN-1:0]      mtvecWdata,
  input  logic                 stvecWe,
  input  logic [XLEN-1:0]      stvecWdata,
  input  logic                 medelegWe,
  input  logic [NUM_CAUSE-1:0] medelegWdata,
  output logic [1:0]           curPriv,
  output logic                 redirectValid,
  output logic [XLEN-1:0]      redirectPc,
  output logic [XLEN-1:0]      mstatus,
  output logic [XLEN-1:0]      mepc,
  output logic [XLEN-1:0]      mcause,
  output logic [XLEN-1:0]      sepc,
  output logic [XLEN-1:0]      scause
);
  trapCmd_t               cmd;
  logic [CAUSE_W-1:0]     effCause;
  logic [NUM_CAUSE-1:0]   medeleg;

  privCtrl #(.CAUSE_W(CAUSE_W)) ctrl (
    .trapReq(trapReq), .trapIsEcall(trapIsEcall), .trapCause(trapCause),
    .mretReq(mretReq), .sretReq(sretReq), .mstatusWe(mstatusWe),
    .curPriv(curPriv), .medeleg(medeleg), .cmd(cmd), .effCause(effCause)
  );

  privDatapath #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .effCause(effCause), .trapEpc(trapEpc),
    .mstatusWdata(mstatusWdata), .mtvecWe(mtvecWe), .mtvecWdata(mtvecWdata),
    .stvecWe(stvecWe), .stvecWdata(stvecWdata), .medelegWe(medelegWe),
    .medelegWdata(medelegWdata), .curPriv(curPriv), .medeleg(medeleg),
    .redirectPc(redirectPc), .mstatus(mstatus), .mepc(mepc), .mcause(mcause),
    .sepc(sepc), .scause(scause)
  );

  assign redirectValid = trapReq || mretReq || sretReq;

  // R12
  redirect_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> $onehot0({cmd.enterM, cmd.enterS, cmd.leaveM, cmd.leaveS}));
endmodule

// File: tb/privTrapUnit_test.sv
module privTrapUnit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trapReq = 0, trapIsEcall = 0, mretReq = 0, sretReq = 0;
  logic [4:0] trapCause = '0;
  logic [31:0] trapEpc = '0;
  logic mstatusWe = 0, mtvecWe = 0, stvecWe = 0, medelegWe = 0;
  logic [31:0] mstatusWdata = '0, mtvecWdata = '0, stvecWdata = '0, medelegWdata = '0;
  logic [1:0] curPriv;
  logic redirectValid;
  logic [31:0] redirectPc, mstatus, mepc, mcause, sepc, scause;

  int tests = 0;
  int fails = 0;

  // expected state, computed from the requirements
  logic [1:0] ePriv = 2'b11, eMpp = 2'b11;
  bit eSpp = 0, eMie = 0, eMpie = 0;
  logic [31:0] eMepc = 0, eMcause = 0, eSepc = 0, eScause = 0;
  logic [31:0] eMtvec = 0, eStvec = 0, eMedeleg = 0;

  always #5 clk = ~clk;

  privTrapUnit uut (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapIsEcall(trapIsEcall),
    .trapCause(trapCause), .trapEpc(trapEpc), .mretReq(mretReq), .sretReq(sretReq),
    .mstatusWe(mstatusWe), .mstatusWdata(mstatusWdata), .mtvecWe(mtvecWe),
    .mtvecWdata(mtvecWdata), .stvecWe(stvecWe), .stvecWdata(stvecWdata),
    .medelegWe(medelegWe), .medelegWdata(medelegWdata), .curPriv(curPriv),
    .redirectValid(redirectValid), .redirectPc(redirectPc), .mstatus(mstatus),
    .mepc(mepc), .mcause(mcause), .sepc(sepc), .scause(scause)
  );

  function automatic logic [31:0] expStatus();
    return {19'b0, eMpp, 2'b00, eSpp, eMpie, 3'b000, eMie, 3'b000};
  endfunction

  task automatic checkState(input string tag);
    tests++;
    if (curPriv !== ePriv || mstatus !== expStatus() || mepc !== eMepc ||
        mcause !== eMcause || sepc !== eSepc || scause !== eScause) begin
      fails++;
      $display("FAIL %s state: priv=%0d mstatus=%h mepc=%h mcause=%0d sepc=%h scause=%0d expected priv=%0d mstatus=%h mepc=%h mcause=%0d sepc=%h scause=%0d",
        tag, curPriv, mstatus, mepc, mcause, sepc, scause,
        ePriv, expStatus(), eMepc, eMcause, eSepc, eScause);
    end
  endtask

  task automatic step(input bit tr, input bit ec, input logic [4:0] cs,
                      input logic [31:0] epc, input bit mr, input bit sr,
                      input bit msWe, input logic [31:0] msD,
                      input bit mtWe, input logic [31:0] mtD,
                      input bit stWe, input logic [31:0] stD,
                      input bit mdWe, input logic [31:0] mdD, input string tag);
    logic [4:0] c;
    logic [31:0] rd;
    bit rv;
    @(negedge clk);
    trapReq = tr; trapIsEcall = ec; trapCause = cs; trapEpc = epc;
    mretReq = mr; sretReq = sr; mstatusWe = msWe; mstatusWdata = msD;
    mtvecWe = mtWe; mtvecWdata = mtD; stvecWe = stWe; stvecWdata = stD;
    medelegWe = mdWe; medelegWdata = mdD;
    rv = tr || mr || sr;
    rd = 0;
    c = ec ? ((ePriv == 2'b00) ? 5'd8 : (ePriv == 2'b01) ? 5'd9 : 5'd11) : cs;
    if (tr) begin
      if (ePriv != 2'b11 && eMedeleg[c]) begin
        rd = eStvec; eSepc = epc; eScause = {27'b0, c};
        eSpp = (ePriv == 2'b01); ePriv = 2'b01;
      end else begin
        rd = eMtvec; eMepc = epc; eMcause = {27'b0, c};
        eMpp = ePriv; ePriv = 2'b11; eMpie = eMie; eMie = 0;
      end
    end else if (mr) begin
      rd = eMepc; ePriv = eMpp; eMpp = 2'b11; eMie = eMpie; eMpie = 1;
    end else if (sr) begin
      rd = eSepc; ePriv = {1'b0, eSpp}; eSpp = 0;
    end else if (msWe) begin
      eMie = msD[3]; eMpie = msD[7]; eSpp = msD[8];
      eMpp = (msD[12:11] == 2'b11) ? 2'b11 : 2'b01;
    end
    if (mtWe) eMtvec = {mtD[31:2], 2'b00};
    if (stWe) eStvec = {stD[31:2], 2'b00};
    if (mdWe) eMedeleg = mdD;
    #1;
    tests++;
    if (redirectValid !== rv || (rv && redirectPc !== rd)) begin
      fails++;
      $display("FAIL %s redirect: valid=%0b pc=%h expected valid=%0b pc=%h",
               tag, redirectValid, redirectPc, rv, rd);
    end
    @(posedge clk);
    #1;
    checkState(tag);
    @(negedge clk);
    trapReq = 0; trapIsEcall = 0; mretReq = 0; sretReq = 0;
    mstatusWe = 0; mtvecWe = 0; stvecWe = 0; medelegWe = 0;
  endtask

  task automatic doTrap(input bit ec, input logic [4:0] cs, input logic [31:0] epc, input string tag);
    step(1, ec, cs, epc, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic doMret(input string tag);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic doSret(input string tag);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wrStatus(input logic [31:0] d, input string tag);
    step(0, 0, 0, 0, 0, 0, 1, d, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wrVectors(input logic [31:0] mt, input logic [31:0] st, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, mt, 1, st, 0, 0, tag);
  endtask
  task automatic wrDeleg(input logic [31:0] d, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, d, tag);
  endtask

  task automatic setPriv(input logic [1:0] p);
    if (ePriv != 2'b11) begin
      wrDeleg(0, "R11");
      doTrap(0, 5'd2, 32'h100, "R3");
    end
    if (p == 2'b01) begin
      wrStatus(32'h0000_0800, "R6");
      doMret("R5");
    end else if (p == 2'b00) begin
      wrStatus(32'h0, "R6");
      doSret("R9");
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1 checkState("R1");

    // R7: full-width vector bases, mode bits dropped
    wrVectors(32'h0000_51F9, 32'h0000_A37E, "R7");
    doTrap(0, 5'd3, 32'h2000, "R7");
    wrVectors(32'hFFFF_FFFF, 32'h8000_0003, "R7");
    doTrap(0, 5'd3, 32'h2004, "R7");
    wrVectors(32'h0000_51F8, 32'h0001_2340, "R7");

    // R6: all four MPP encodings, then mret shows stored value
    for (int v = 0; v < 4; v++) begin
      setPriv(2'b11);
      wrStatus(32'(v) << 11, "R6");
      doMret("R6");
    end

    // R4: MIE/MPIE round trip
    setPriv(2'b11);
    wrStatus(32'h0000_1808, "R4");
    doTrap(0, 5'd7, 32'h3000, "R4");
    doMret("R4");
    wrStatus(32'h0000_1880, "R4");
    doTrap(0, 5'd7, 32'h3004, "R4");
    doMret("R4");

    // R3 R8 R11: every cause, every privilege, delegation bit on and off
    for (int p = 0; p < 3; p++) begin
      for (int cs = 0; cs < 32; cs++) begin
        for (int d = 0; d < 2; d++) begin
          logic [1:0] pp;
          logic [31:0] mask;
          pp = (p == 2) ? 2'b11 : 2'(p);
          mask = d ? (32'h1 << cs) : ~(32'h1 << cs);
          setPriv(pp);
          wrDeleg(mask, "R8");
          doTrap(0, 5'(cs), 32'h4000 + 32'(cs * 4), (pp == 2'b11) ? "R11" : (d ? "R8" : "R3"));
          if (ePriv == 2'b01) doSret("R9");
          else doMret("R5");
        end
      end
    end

    // R2: environment call cause from each privilege, with and without delegation
    for (int p = 0; p < 3; p++) begin
      for (int d = 0; d < 2; d++) begin
        logic [1:0] pp;
        pp = (p == 2) ? 2'b11 : 2'(p);
        setPriv(pp);
        wrDeleg(d ? 32'h0000_0B00 : 32'h0, "R2");
        doTrap(1, 5'd1, 32'h5000 + 32'(p), "R2");
      end
    end

    // R10: collisions
    setPriv(2'b01);
    wrDeleg(0, "R10");
    step(1, 0, 5'd4, 32'h6000, 1, 1, 1, 32'h0, 0, 0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 1, 1, 1, 32'h0, 0, 0, 0, 0, 0, 0, "R10");
    setPriv(2'b11);
    wrStatus(32'h0000_0100, "R10");
    step(0, 0, 0, 0, 0, 1, 1, 32'h0000_1888, 0, 0, 0, 0, 0, 0, "R10");
    setPriv(2'b00);
    step(1, 0, 5'd5, 32'h6100, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h20, "R10");
    setPriv(2'b00);
    step(1, 0, 5'd5, 32'h6200, 0, 0, 0, 0, 1, 32'h7000, 1, 32'h7100, 0, 0, "R10");
    doSret("R12");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule